// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block serialises one character at a time onto an asynchronous serial line. Timing is counted in baud ticks that arrive at sixteen times the bit rate, so every full bit spans sixteen ticks. The frame format comes from an 8-bit mode word, which sets the character width, the parity rule, the stop length and an internal loopback path. Fractional stop lengths of 9/16 and 1+9/16 bit are counted in ticks. Space parity is supported.

A character is offered with a valid/ready handshake and is accepted only while the transmitter is enabled and idle. Separate one-cycle commands enable and disable the transmitter. The mode word is captured together with the character, so software may rewrite it at any time without corrupting a frame already on the line. A one-cycle done pulse marks the end of the stop time. In loopback the frame appears on the receiver-side output and the external line stays idle.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset `tx_line` and `loop_rx` are high, `busy` and `done` are low, and `tx_ready` is low because the transmitter starts disabled.
- R2: `tx_ready` is high only while the transmitter is enabled and idle. A pulse on `en_cmd` enables it and a pulse on `dis_cmd` disables it. When both arrive in the same cycle the transmitter ends up disabled.
- R3: An accepted frame starts with a low start bit of 16 ticks. The data bits follow least significant first, 16 ticks each. The count of data bits is set by mode[5:4]: 0, 1, 2 and 3 select 5, 6, 7 and 8 bits.
- R4: mode[1:0] selects the parity bit: 0 means none, 1 odd, 2 even, 3 space (always 0). The parity bit lasts 16 ticks and is computed over the configured data bits only. Data bits above the configured width have no effect on the line.
- R5: mode[3:2] sets the high stop time: 0 gives 9 ticks, 1 gives 16, 2 gives 25 and 3 gives 32. Mode 0x34 therefore produces 8 data bits, no parity and one stop bit.
- R6: At the end of the stop time `done` is high for exactly one cycle and `busy` falls in that same cycle.
- R7: With mode[7] set, the frame appears on `loop_rx` and `tx_line` stays high. With mode[7] clear, `loop_rx` stays high.
- R8: The mode word is captured when a character is accepted. Changing it during a frame does not alter that frame.
- R9: A disable issued during a frame lets that frame finish unchanged. After it no further character is accepted until the next enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| mode | input | 8 | Frame format: [7] loopback, [5:4] width, [3:2] stop, [1:0] parity |
| tx_data | input | 8 | Character to send |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Character accepted this cycle when valid |
| en_cmd | input | 1 | Enable-transmitter command pulse |
| dis_cmd | input | 1 | Disable-transmitter command pulse |
| tx_line | output | 1 | Serial output, idles high |
| loop_rx | output | 1 | Receiver-side copy of the frame in loopback, else high |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The hardest situations to reach from the ports are those where control inputs move while a frame is on the line. These are a mode rewrite during a frame and a disable command during a frame. The bench starts a frame and, right after the handshake cycle, drives a different mode word or pulses the disable command. It then compares the whole tick-by-tick waveform against one computed from the original mode word. Beyond that, every combination of width, stop length and parity is swept. Each combination is sent with two data bytes whose upper bits are set, and some of the sweep runs in loopback.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int OS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic [7:0] mode,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic       en_cmd,
  input  logic       dis_cmd,
  output logic       tx_line,
  output logic       loop_rx,
  output logic       busy,
  output logic       done
);
  localparam int TW = $clog2(2 * OS + 1);
  localparam logic [TW-1:0] T_BIT  = TW'(OS);
  localparam logic [TW-1:0] T_FRAC = TW'((OS * 9) / 16);
  localparam logic [TW-1:0] T_ONEF = TW'(OS + (OS * 9) / 16);
  localparam logic [TW-1:0] T_TWO  = TW'(2 * OS);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic          en_q;
  logic [7:0]    sh;
  logic [2:0]    bits_left;
  logic [TW-1:0] left;
  logic [1:0]    par_q;
  logic [1:0]    stop_q;
  logic          par_bit_q;
  logic          lb_q;
  logic          done_q;
  logic          frame_line;

  wire       accept = tx_valid && tx_ready;
  wire [7:0] masked = tx_data & (8'hFF >> (2'd3 - mode[5:4]));
  wire       xor_p  = ^masked;
  wire       par_in = (mode[1:0] == 2'd1) ? ~xor_p :
                      (mode[1:0] == 2'd2) ?  xor_p : 1'b0;

  function automatic logic [TW-1:0] stop_len(input logic [1:0] s);
    case (s)
      2'd0:    stop_len = T_FRAC;
      2'd1:    stop_len = T_BIT;
      2'd2:    stop_len = T_ONEF;
      default: stop_len = T_TWO;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      en_q      <= 1'b0;
      sh        <= '0;
      bits_left <= '0;
      left      <= '0;
      par_q     <= '0;
      stop_q    <= '0;
      par_bit_q <= 1'b0;
      lb_q      <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (dis_cmd)     en_q <= 1'b0;
      else if (en_cmd) en_q <= 1'b1;
      if (st == S_IDLE) begin
        if (accept) begin
          st        <= S_START;
          left      <= T_BIT;
          sh        <= tx_data;
          bits_left <= {1'b0, mode[5:4]} + 3'd4;
          par_q     <= mode[1:0];
          stop_q    <= mode[3:2];
          par_bit_q <= par_in;
          lb_q      <= mode[7];
        end
      end else if (baud_tick) begin
        if (left != TW'(1)) begin
          left <= left - TW'(1);
        end else begin
          case (st)
            S_START: begin
              st   <= S_DATA;
              left <= T_BIT;
            end
            S_DATA: begin
              sh <= sh >> 1;
              if (bits_left != 3'd0) begin
                bits_left <= bits_left - 3'd1;
                left      <= T_BIT;
              end else if (par_q != 2'd0) begin
                st   <= S_PAR;
                left <= T_BIT;
              end else begin
                st   <= S_STOP;
                left <= stop_len(stop_q);
              end
            end
            S_PAR: begin
              st   <= S_STOP;
              left <= stop_len(stop_q);
            end
            default: begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  always_comb begin
    case (st)
      S_START: frame_line = 1'b0;
      S_DATA:  frame_line = sh[0];
      S_PAR:   frame_line = par_bit_q;
      default: frame_line = 1'b1;
    endcase
  end

  assign tx_ready = en_q && (st == S_IDLE);
  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign tx_line  = lb_q ? 1'b1 : frame_line;
  assign loop_rx  = lb_q ? frame_line : 1'b1;
endmodule

module uart_frame_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       tx_line,
  input logic       loop_rx,
  input logic       busy,
  input logic       done,
  input logic       lb_q,
  input logic [1:0] par_q,
  input logic [1:0] stop_q
);
  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !busy);
  assert_accept_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> busy);
  assert_busy_from_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tx_valid && tx_ready));
  assert_done_ends_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tx_line && loop_rx));
  assert_loop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lb_q |-> tx_line);
  assert_mode_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(lb_q) && $stable(par_q) && $stable(stop_q)));
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_line(tx_line), .loop_rx(loop_rx), .busy(busy), .done(done),
  .lb_q(lb_q), .par_q(par_q), .stop_q(stop_q)
);

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [7:0] mode = 8'h34;
  logic [7:0] tx_data = 8'h00;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic       en_cmd = 1'b0;
  logic       dis_cmd = 1'b0;
  logic       tx_line, loop_rx, busy, done;

  int errors = 0;
  int checks = 0;
  bit got[$];
  bit lb_exp = 1'b0;
  int other_bad = 0;
  int done_seen = 0;

  uart_frame_tx dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .mode(mode),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .en_cmd(en_cmd), .dis_cmd(dis_cmd), .tx_line(tx_line),
    .loop_rx(loop_rx), .busy(busy), .done(done)
  );

  always #10 clk = ~clk;

  always @(posedge clk) baud_tick <= ~baud_tick;

  always @(negedge clk) if (rst_n) begin
    if (baud_tick && busy) begin
      got.push_back(lb_exp ? loop_rx : tx_line);
      if ((lb_exp ? tx_line : loop_rx) !== 1'b1) other_bad++;
    end
    if (done) done_seen++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input bit en, input bit dis);
    @(negedge clk);
    en_cmd  = en;
    dis_cmd = dis;
    @(negedge clk);
    en_cmd  = 1'b0;
    dis_cmd = 1'b0;
  endtask

  // Sends one frame; after the handshake optionally rewrites mode or disables.
  task automatic send(input logic [7:0] m, input logic [7:0] d,
                      input logic [7:0] m_after, input bit dis_mid, input string req);
    bit exp[$];
    int nb, ones, stop_t, par, mism;
    @(negedge clk);
    got.delete();
    other_bad = 0;
    done_seen = 0;
    lb_exp  = m[7];
    mode    = m;
    tx_data = d;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    mode = m_after;
    if (dis_mid) begin
      dis_cmd = 1'b1;
      @(negedge clk);
      dis_cmd = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    nb = 5 + int'(m[5:4]);
    ones = 0;
    for (int i = 0; i < 16; i++) exp.push_back(1'b0);
    for (int b = 0; b < nb; b++) begin
      ones += int'(d[b]);
      for (int i = 0; i < 16; i++) exp.push_back(d[b]);
    end
    case (m[1:0])
      2'd1: par = (ones % 2 == 0) ? 1 : 0;
      2'd2: par = ones % 2;
      default: par = 0;
    endcase
    if (m[1:0] != 2'd0)
      for (int i = 0; i < 16; i++) exp.push_back(par[0]);
    case (m[3:2])
      2'd0: stop_t = 9;
      2'd1: stop_t = 16;
      2'd2: stop_t = 25;
      default: stop_t = 32;
    endcase
    for (int i = 0; i < stop_t; i++) exp.push_back(1'b1);
    mism = -1;
    if (got.size() == exp.size()) begin
      for (int i = 0; i < exp.size(); i++)
        if (mism < 0 && got[i] != exp[i]) mism = i;
    end else mism = 9999;
    check(mism < 0, {req, " waveform (R3 R4 R5) mismatch index"}, mism, -1);
    check(got.size() == exp.size(), {req, " frame length ticks"}, got.size(), exp.size());
    check(done_seen == 1, "R6 done pulse count", done_seen, 1);
    check(other_bad == 0, "R7 unused line stays high", other_bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(tx_line === 1'b1, "R1 tx_line", tx_line, 1);
    check(loop_rx === 1'b1, "R1 loop_rx", loop_rx, 1);
    check(busy === 1'b0, "R1 busy", busy, 0);
    check(done === 1'b0, "R1 done", done, 0);
    check(tx_ready === 1'b0, "R1 ready while disabled", tx_ready, 0);

    // R2 offer while disabled: nothing accepted
    tx_valid = 1'b1;
    repeat (40) @(negedge clk);
    check(busy === 1'b0, "R2 no frame while disabled", busy, 0);
    check(tx_line === 1'b1, "R2 line idle while disabled", tx_line, 1);
    tx_valid = 1'b0;

    // R2 enable and disable together: disable wins
    pulse(1'b1, 1'b1);
    check(tx_ready === 1'b0, "R2 disable wins", tx_ready, 0);
    pulse(1'b1, 1'b0);
    check(tx_ready === 1'b1, "R2 enabled and idle", tx_ready, 1);

    // R5 default 8-N-1
    send(8'h34, 8'h5A, 8'h34, 1'b0, "R5 8N1");

    // R3 R4 R5 sweep of all formats, upper data bits set
    for (int m = 0; m < 64; m++) begin
      send(8'(m), 8'hE5, 8'(m), 1'b0, "R4 sweep a");
      send(8'(m) | 8'h80, 8'h3A, 8'(m) | 8'h80, 1'b0, "R7 sweep b");
    end

    // R8 mode rewritten mid-frame
    send(8'h1D, 8'h96, 8'hB3, 1'b0, "R8 mode change");
    send(8'h82, 8'h71, 8'h3F, 1'b0, "R8 loopback held");

    // R9 disable mid-frame: frame completes, then nothing accepted
    send(8'h39, 8'hC3, 8'h39, 1'b1, "R9 disable mid-frame");
    check(tx_ready === 1'b0, "R9 ready after disable", tx_ready, 0);
    tx_valid = 1'b1;
    repeat (40) @(negedge clk);
    check(busy === 1'b0, "R9 no new frame", busy, 0);
    tx_valid = 1'b0;
    pulse(1'b1, 1'b0);
    send(8'h34, 8'hFF, 8'h34, 1'b0, "R2 re-enabled");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule